// File: doc/BRIEF.md
# Receive Descriptor Ring Writer

This block stores received Ethernet frames into a ring of fixed-size receive buffers. Frame bytes arrive one per clock on a stream with start, end and abort markers. Each frame is cut into 128-byte slices. Each slice lands in its own buffer of a local byte memory, and a two-word descriptor in a local descriptor store marks what the slice holds. Software walks the same descriptor store through a word read/write port. It reads the buffers through a byte read port and returns each buffer by clearing its ownership bit.

A descriptor is made of an address word and a control word. The address word holds the ownership bit and the ring-wrap bit. The control word holds the first-slice and last-slice flags and the frame length. The input stream cannot be stalled. If the descriptor the block needs next is still owned by hardware, the block drops the data and flags the event in three sticky status bits, which software clears by writing ones.

Top module: `rx_ring_writer`

## Requirements
- R1: Byte k of a frame is stored at buffer address d*128 + (k mod 128), where d is the descriptor holding slice k/128. Slices use consecutive descriptors of the ring.
- R2: When the block opens a descriptor, it sets the ownership bit (address word bit 0) and keeps the other address bits.
- R3: Control word bit 14 is set only in the descriptor holding a frame's first slice. Bit 15 is set only in the descriptor holding its last slice. The control word of every descriptor opened for a frame is rewritten, which clears stale bits.
- R4: Control bits 11:0 carry the total frame length, in the last descriptor only. The other descriptors carry 0 there.
- R5: After a descriptor whose address word bit 1 (wrap) is set, the next descriptor used is 0. Descriptor N-1 is always followed by descriptor 0.
- R6: If a frame start needs a descriptor whose ownership bit is set, status bit 1 (buffer unavailable) is set. The frame is dropped with no write, and a later frame retries the same descriptor.
- R7: If a frame in progress needs a further descriptor that is still owned, status bits 1 and 2 (overrun) are set. The rest of the frame is dropped, and the descriptors already filled stay owned without an end flag.
- R8: Status bit 0 (receive complete) is set for every stored frame end. Status bits are 0 after reset and stay set until written with 1 on sts_clr_i. Writing 0 leaves a bit unchanged.
- R9: An abort ends the frame in progress. The descriptors it used stay owned, with no end flag, and the next frame starts at the following descriptor.
- R10: Bytes that arrive outside a frame, with no start marker, are ignored. They change no descriptor and no status bit.
- R11: A start marker inside a frame abandons that frame, as an abort does, and begins the new frame in the next descriptor.
- R12: A frame of exactly 128 bytes uses one descriptor, which carries both flags. A frame of 129 bytes uses two descriptors.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| rx_valid_i | input | 1 | Byte valid on the receive stream |
| rx_data_i | input | 8 | Received byte |
| rx_sof_i | input | 1 | Marks the first byte of a frame |
| rx_eof_i | input | 1 | Marks the last byte of a frame |
| rx_abort_i | input | 1 | Cancels the frame in progress |
| sw_we_i | input | 1 | Software descriptor word write |
| sw_idx_i | input | IDX_W | Descriptor index for software access |
| sw_sel_i | input | 1 | Word select: 0 address word, 1 control word |
| sw_wdata_i | input | 32 | Software write data |
| sw_rdata_o | output | 32 | Selected descriptor word |
| buf_addr_i | input | BUF_AW | Buffer memory byte address for software read |
| buf_rdata_o | output | 8 | Buffer memory read data |
| sts_clr_i | input | 3 | Write-one-to-clear strobes for the status bits |
| sts_o | output | 3 | Status: bit 0 complete, bit 1 unavailable, bit 2 overrun |

## Verification
A byte that is sampled at a rising edge becomes visible in the buffer memory and the descriptor words at that same edge. The status bits it causes are also set at that edge. Both read ports are combinational, so results can be read before the next edge. The bench drives every input on a falling edge and drops the stream one falling edge after the last byte. It reads descriptors, buffer bytes and status only after that idle falling edge, when every register has taken its final value and no further byte is in flight.

// File: rtl/rxr_pkg.sv
package rxr_pkg;
  localparam int WORD_W   = 32;
  localparam int USED_BIT = 0;
  localparam int WRAP_BIT = 1;
  localparam int SOF_BIT  = 14;
  localparam int EOF_BIT  = 15;
  localparam int LEN_W    = 12;
  localparam int STS_W    = 3;
  localparam int STS_CMP  = 0;
  localparam int STS_UNAV = 1;
  localparam int STS_OVR  = 2;
endpackage

// File: rtl/rxr_desc_ram.sv
module rxr_desc_ram
  import rxr_pkg::*;
#(
  parameter int N_DESC = 16,
  localparam int IDX_W = $clog2(N_DESC)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              hw_we_i,
  input  logic [IDX_W-1:0]  hw_idx_i,
  input  logic              hw_set_used_i,
  input  logic [WORD_W-1:0] hw_ctrl_i,
  input  logic [IDX_W-1:0]  chk_idx_i,
  output logic [WORD_W-1:0] chk_addr_o,
  input  logic              sw_we_i,
  input  logic [IDX_W-1:0]  sw_idx_i,
  input  logic              sw_sel_i,
  input  logic [WORD_W-1:0] sw_wdata_i,
  output logic [WORD_W-1:0] sw_rdata_o
);
  logic [WORD_W-1:0] addr_q [N_DESC];
  logic [WORD_W-1:0] ctrl_q [N_DESC];

  // software write lands after the hardware update, so it wins on a clash
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < N_DESC; i++) begin
        addr_q[i] <= '0;
        ctrl_q[i] <= '0;
      end
    end else begin
      if (hw_we_i) begin
        ctrl_q[hw_idx_i] <= hw_ctrl_i;
        if (hw_set_used_i) addr_q[hw_idx_i] <= addr_q[hw_idx_i] | WORD_W'(1 << USED_BIT);
      end
      if (sw_we_i) begin
        if (sw_sel_i) ctrl_q[sw_idx_i] <= sw_wdata_i;
        else          addr_q[sw_idx_i] <= sw_wdata_i;
      end
    end
  end

  assign chk_addr_o = addr_q[chk_idx_i];
  assign sw_rdata_o = sw_sel_i ? ctrl_q[sw_idx_i] : addr_q[sw_idx_i];

  AST_OPEN_FREE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hw_we_i && hw_set_used_i) |-> !addr_q[hw_idx_i][USED_BIT]) else $error("owned descriptor opened"); // R6
  AST_EOF_LEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hw_we_i && hw_ctrl_i[EOF_BIT]) |-> (hw_ctrl_i[LEN_W-1:0] != '0)) else $error("end without length"); // R4
endmodule

// File: rtl/rxr_buf_ram.sv
module rxr_buf_ram #(
  parameter int DEPTH = 2048,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic          clk_i,
  input  logic          we_i,
  input  logic [AW-1:0] waddr_i,
  input  logic [7:0]    wdata_i,
  input  logic [AW-1:0] raddr_i,
  output logic [7:0]    rdata_o
);
  logic [7:0] mem_q [DEPTH];

  always_ff @(posedge clk_i) begin
    if (we_i) mem_q[waddr_i] <= wdata_i;
  end

  assign rdata_o = mem_q[raddr_i];
endmodule

// File: rtl/rxr_rx_ctrl.sv
module rxr_rx_ctrl
  import rxr_pkg::*;
#(
  parameter int N_DESC    = 16,
  parameter int BUF_BYTES = 128,
  localparam int IDX_W  = $clog2(N_DESC),
  localparam int OFF_W  = $clog2(BUF_BYTES),
  localparam int BUF_AW = IDX_W + OFF_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              rx_valid_i,
  input  logic [7:0]        rx_data_i,
  input  logic              rx_sof_i,
  input  logic              rx_eof_i,
  input  logic              rx_abort_i,
  output logic [IDX_W-1:0]  chk_idx_o,
  input  logic [WORD_W-1:0] chk_addr_i,
  output logic              desc_we_o,
  output logic [IDX_W-1:0]  desc_idx_o,
  output logic              desc_set_used_o,
  output logic [WORD_W-1:0] desc_ctrl_o,
  output logic              buf_we_o,
  output logic [BUF_AW-1:0] buf_addr_o,
  output logic [7:0]        buf_data_o,
  output logic              set_cmp_o,
  output logic              set_unav_o,
  output logic              set_ovr_o
);
  logic             in_frame_q, first_q;
  logic [OFF_W-1:0] off_q;
  logic [IDX_W-1:0] act_idx_q, wr_idx_q, wr_next;
  logic [LEN_W-1:0] len_q, frame_len;

  logic             live, open_need, do_open, fail, byte_wr, is_first, end_now;
  logic [IDX_W-1:0] byte_idx;
  logic [OFF_W-1:0] byte_off;

  always_comb begin
    live      = rx_valid_i && !rx_abort_i;
    open_need = live && (rx_sof_i || (in_frame_q && off_q == '0));
    do_open   = open_need && !chk_addr_i[USED_BIT];
    fail      = open_need &&  chk_addr_i[USED_BIT];
    byte_wr   = do_open || (live && !rx_sof_i && in_frame_q && off_q != '0);
    byte_idx  = do_open ? wr_idx_q : act_idx_q;
    byte_off  = do_open ? '0 : off_q;
    is_first  = do_open ? rx_sof_i : first_q;
    frame_len = (do_open && rx_sof_i) ? LEN_W'(1) : len_q + LEN_W'(1);
    end_now   = byte_wr && rx_eof_i;
    wr_next   = (chk_addr_i[WRAP_BIT] || wr_idx_q == IDX_W'(N_DESC - 1)) ? '0 : wr_idx_q + IDX_W'(1);

    desc_ctrl_o          = '0;
    desc_ctrl_o[SOF_BIT] = is_first;
    if (end_now) begin
      desc_ctrl_o[EOF_BIT]     = 1'b1;
      desc_ctrl_o[LEN_W-1:0]   = frame_len;
    end
  end

  assign chk_idx_o       = wr_idx_q;
  assign desc_we_o       = do_open || end_now;
  assign desc_idx_o      = byte_idx;
  assign desc_set_used_o = do_open;
  assign buf_we_o        = byte_wr;
  assign buf_addr_o      = {byte_idx, byte_off};
  assign buf_data_o      = rx_data_i;
  assign set_cmp_o       = end_now;
  assign set_unav_o      = fail;
  assign set_ovr_o       = fail && !rx_sof_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      in_frame_q <= 1'b0;
      first_q    <= 1'b0;
      off_q      <= '0;
      act_idx_q  <= '0;
      wr_idx_q   <= '0;
      len_q      <= '0;
    end else if (rx_abort_i || fail) begin
      in_frame_q <= 1'b0;
      off_q      <= '0;
    end else if (byte_wr) begin
      if (do_open) wr_idx_q <= wr_next;
      act_idx_q <= byte_idx;
      first_q   <= is_first;
      len_q     <= frame_len;
      if (end_now) begin
        in_frame_q <= 1'b0;
        off_q      <= '0;
      end else begin
        in_frame_q <= 1'b1;
        off_q      <= byte_off + OFF_W'(1);  // wraps to 0 when the slice is full
      end
    end
  end

  AST_IDLE_OFF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !in_frame_q |-> (off_q == '0)) else $error("offset held outside frame"); // R9
  AST_FAIL_NO_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (set_unav_o) |-> !buf_we_o) else $error("byte stored on unavailable buffer"); // R6
endmodule

// File: rtl/rx_ring_writer.sv
module rx_ring_writer
  import rxr_pkg::*;
#(
  parameter int N_DESC    = 16,
  parameter int BUF_BYTES = 128,
  localparam int IDX_W  = $clog2(N_DESC),
  localparam int OFF_W  = $clog2(BUF_BYTES),
  localparam int BUF_AW = IDX_W + OFF_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              rx_valid_i,
  input  logic [7:0]        rx_data_i,
  input  logic              rx_sof_i,
  input  logic              rx_eof_i,
  input  logic              rx_abort_i,
  input  logic              sw_we_i,
  input  logic [IDX_W-1:0]  sw_idx_i,
  input  logic              sw_sel_i,
  input  logic [WORD_W-1:0] sw_wdata_i,
  output logic [WORD_W-1:0] sw_rdata_o,
  input  logic [BUF_AW-1:0] buf_addr_i,
  output logic [7:0]        buf_rdata_o,
  input  logic [STS_W-1:0]  sts_clr_i,
  output logic [STS_W-1:0]  sts_o
);
  logic [IDX_W-1:0]  chk_idx, desc_idx;
  logic [WORD_W-1:0] chk_addr, desc_ctrl;
  logic              desc_we, desc_set_used;
  logic              buf_we;
  logic [BUF_AW-1:0] buf_waddr;
  logic [7:0]        buf_wdata;
  logic              set_cmp, set_unav, set_ovr;
  logic [STS_W-1:0]  sts_set, sts_q;

  rxr_rx_ctrl #(.N_DESC(N_DESC), .BUF_BYTES(BUF_BYTES)) u_ctrl (
    .clk_i, .rst_ni, .rx_valid_i, .rx_data_i, .rx_sof_i, .rx_eof_i, .rx_abort_i,
    .chk_idx_o(chk_idx), .chk_addr_i(chk_addr),
    .desc_we_o(desc_we), .desc_idx_o(desc_idx), .desc_set_used_o(desc_set_used),
    .desc_ctrl_o(desc_ctrl),
    .buf_we_o(buf_we), .buf_addr_o(buf_waddr), .buf_data_o(buf_wdata),
    .set_cmp_o(set_cmp), .set_unav_o(set_unav), .set_ovr_o(set_ovr)
  );

  rxr_desc_ram #(.N_DESC(N_DESC)) u_desc (
    .clk_i, .rst_ni,
    .hw_we_i(desc_we), .hw_idx_i(desc_idx), .hw_set_used_i(desc_set_used), .hw_ctrl_i(desc_ctrl),
    .chk_idx_i(chk_idx), .chk_addr_o(chk_addr),
    .sw_we_i, .sw_idx_i, .sw_sel_i, .sw_wdata_i, .sw_rdata_o
  );

  rxr_buf_ram #(.DEPTH(N_DESC * BUF_BYTES)) u_buf (
    .clk_i, .we_i(buf_we), .waddr_i(buf_waddr), .wdata_i(buf_wdata),
    .raddr_i(buf_addr_i), .rdata_o(buf_rdata_o)
  );

  always_comb begin
    sts_set           = '0;
    sts_set[STS_CMP]  = set_cmp;
    sts_set[STS_UNAV] = set_unav;
    sts_set[STS_OVR]  = set_ovr;
  end

  // a new event beats a clear strobe in the same cycle
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sts_q <= '0;
    else         sts_q <= (sts_q & ~sts_clr_i) | sts_set;
  end

  assign sts_o = sts_q;

  for (genvar k = 0; k < STS_W; k++) begin : g_sts_chk
    AST_STS_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (sts_q[k] && !sts_clr_i[k]) |=> sts_q[k]) else $error("status bit lost"); // R8
  end

  AST_OVR_WITH_UNAV: assert property (@(posedge clk_i) disable iff (!rst_ni)
    set_ovr |-> set_unav) else $error("overrun without unavailable"); // R7
endmodule

// File: tb/rx_ring_writer_test.sv
`timescale 1ns/1ps
module rx_ring_writer_test;
  localparam int N_DESC = 16;
  localparam int IDX_W  = 4;
  localparam int BUF_AW = 11;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        rx_valid = 1'b0, rx_sof = 1'b0, rx_eof = 1'b0, rx_abort = 1'b0;
  logic [7:0]  rx_data = '0;
  logic        sw_we = 1'b0, sw_sel = 1'b0;
  logic [IDX_W-1:0]  sw_idx = '0;
  logic [31:0] sw_wdata = '0, sw_rdata;
  logic [BUF_AW-1:0] buf_addr = '0;
  logic [7:0]  buf_rdata;
  logic [2:0]  sts_clr = '0, sts;

  int checks = 0, fails = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  rx_ring_writer uut (
    .clk_i(clk), .rst_ni(rst_n),
    .rx_valid_i(rx_valid), .rx_data_i(rx_data), .rx_sof_i(rx_sof), .rx_eof_i(rx_eof), .rx_abort_i(rx_abort),
    .sw_we_i(sw_we), .sw_idx_i(sw_idx), .sw_sel_i(sw_sel), .sw_wdata_i(sw_wdata), .sw_rdata_o(sw_rdata),
    .buf_addr_i(buf_addr), .buf_rdata_o(buf_rdata),
    .sts_clr_i(sts_clr), .sts_o(sts)
  );

  task automatic chk(string tag, logic [31:0] got, logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s got=%h exp=%h", tag, got, exp);
    end
  endtask

  task automatic rd_desc(int idx, bit sel, output logic [31:0] v);
    sw_idx = IDX_W'(idx); sw_sel = sel; #1; v = sw_rdata;
  endtask

  task automatic chk_desc(string tag, int idx, logic [31:0] exp_addr, logic [31:0] exp_ctrl);
    logic [31:0] v;
    rd_desc(idx, 1'b0, v); chk({tag, " addr"}, v, exp_addr);
    rd_desc(idx, 1'b1, v); chk({tag, " ctrl"}, v, exp_ctrl);
  endtask

  task automatic chk_buf(string tag, int a, logic [7:0] exp);
    buf_addr = BUF_AW'(a); #1; chk(tag, {24'h0, buf_rdata}, {24'h0, exp});
  endtask

  task automatic wr_desc(int idx, bit sel, logic [31:0] d);
    @(negedge clk); sw_we = 1'b1; sw_idx = IDX_W'(idx); sw_sel = sel; sw_wdata = d;
    @(negedge clk); sw_we = 1'b0;
  endtask

  task automatic clr_sts(logic [2:0] m);
    @(negedge clk); sts_clr = m;
    @(negedge clk); sts_clr = '0;
  endtask

  task automatic send(int len, logic [7:0] seed, bit with_sof, bit with_eof);
    for (int i = 0; i < len; i++) begin
      @(negedge clk);
      rx_valid = 1'b1; rx_data = seed + 8'(i);
      rx_sof = with_sof && (i == 0); rx_eof = with_eof && (i == len - 1);
    end
    @(negedge clk); rx_valid = 1'b0; rx_sof = 1'b0; rx_eof = 1'b0;
  endtask

  task automatic abort_frame();
    @(negedge clk); rx_abort = 1'b1;
    @(negedge clk); rx_abort = 1'b0;
  endtask

  task automatic t_reset();
    chk("R8 reset status", {29'h0, sts}, 32'h0);
    chk_desc("R2 reset desc0", 0, 32'h0, 32'h0);
  endtask

  task automatic t_multi_slice();
    send(200, 8'h20, 1, 1);
    chk_desc("R2 R3 desc0", 0, 32'h1, 32'h4000);
    chk_desc("R3 R4 desc1", 1, 32'h1, 32'h8000 | 200);
    chk_buf("R1 byte0", 0, 8'h20);
    chk_buf("R1 byte130", 130, 8'h20 + 8'd130);
    chk("R8 complete", {29'h0, sts}, 32'h1);
    clr_sts(3'b001);
    chk("R8 cleared", {29'h0, sts}, 32'h0);
  endtask

  task automatic t_exact();
    send(128, 8'h30, 1, 1);
    chk_desc("R12 128 bytes", 2, 32'h1, 32'hC000 | 128);
    send(129, 8'h40, 1, 1);
    chk_desc("R12 129 first", 3, 32'h1, 32'h4000);
    chk_desc("R12 129 last", 4, 32'h1, 32'h8000 | 129);
    chk_buf("R12 byte128", 4 * 128, 8'h40 + 8'd128);
    clr_sts(3'b111);
  endtask

  task automatic t_wrap_unav();
    wr_desc(5, 1'b0, 32'h2);
    send(10, 8'h90, 1, 1);
    chk_desc("R2 R5 wrap desc keeps bit1", 5, 32'h3, 32'hC000 | 10);
    send(5, 8'hA0, 1, 1);
    chk("R6 unavailable status", {29'h0, sts}, 32'h3);
    chk_desc("R6 owned desc0 untouched", 0, 32'h1, 32'h4000);
    chk_buf("R6 no byte stored", 0, 8'h20);
    for (int i = 0; i < N_DESC; i++) wr_desc(i, 1'b0, 32'h0);
    clr_sts(3'b111);
    send(5, 8'h50, 1, 1);
    chk_desc("R5 R6 retry lands at desc0", 0, 32'h1, 32'hC000 | 5);
    chk_buf("R5 desc0 byte0", 0, 8'h50);
    clr_sts(3'b111);
  endtask

  task automatic t_abort();
    send(150, 8'h60, 1, 0);
    abort_frame();
    chk_desc("R9 first kept", 1, 32'h1, 32'h4000);
    chk_desc("R9 R3 second no end", 2, 32'h1, 32'h0);
    chk_buf("R9 byte149", 2 * 128 + 21, 8'h60 + 8'd149);
    chk("R9 no complete", {29'h0, sts}, 32'h0);
    send(3, 8'h70, 1, 1);
    chk_desc("R9 next frame", 3, 32'h1, 32'hC000 | 3);
    clr_sts(3'b111);
  endtask

  task automatic t_stray();
    send(5, 8'hEE, 0, 1);
    chk("R10 status unchanged", {29'h0, sts}, 32'h0);
    chk_desc("R10 desc4 untouched", 4, 32'h0, 32'h8000 | 129);
    send(2, 8'h80, 1, 1);
    chk_desc("R10 frame after stray", 4, 32'h1, 32'hC000 | 2);
    chk_buf("R10 byte0", 4 * 128, 8'h80);
    chk_buf("R10 byte1", 4 * 128 + 1, 8'h81);
    clr_sts(3'b111);
  endtask

  task automatic t_restart();
    send(140, 8'h00, 1, 0);
    send(4, 8'hC0, 1, 1);
    chk_desc("R11 old first", 5, 32'h1, 32'h4000);
    chk_desc("R11 old second no end", 6, 32'h1, 32'h0);
    chk_desc("R11 new frame", 7, 32'h1, 32'hC000 | 4);
    chk_buf("R11 new byte3", 7 * 128 + 3, 8'hC3);
    clr_sts(3'b111);
  endtask

  task automatic t_overrun();
    wr_desc(9, 1'b0, 32'h1);
    send(300, 8'h10, 1, 1);
    chk("R7 overrun status", {29'h0, sts}, 32'h6);
    chk_desc("R7 filled desc no end", 8, 32'h1, 32'h4000);
    chk_desc("R7 owned desc untouched", 9, 32'h1, 32'h0);
    wr_desc(9, 1'b0, 32'h0);
    clr_sts(3'b111);
    send(6, 8'hD0, 1, 1);
    chk_desc("R7 resume at desc9", 9, 32'h1, 32'hC000 | 6);
    chk("R7 R8 complete only", {29'h0, sts}, 32'h1);
  endtask

  task automatic t_w1c();
    clr_sts(3'b110);
    chk("R8 zero strobe keeps bit", {29'h0, sts}, 32'h1);
    clr_sts(3'b001);
    chk("R8 one clears bit", {29'h0, sts}, 32'h0);
  endtask

  task automatic t_ring_end();
    for (int i = 10; i < N_DESC; i++) send(1, 8'(i), 1, 1);
    chk_desc("R5 last desc", 15, 32'h1, 32'hC000 | 1);
    wr_desc(0, 1'b0, 32'h0);
    send(1, 8'h77, 1, 1);
    chk_desc("R5 natural wrap", 0, 32'h1, 32'hC000 | 1);
    chk_buf("R5 wrap byte", 0, 8'h77);
  endtask

  initial begin
    #10000000;
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog got=%0d exp=%0d", 0, 1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_multi_slice();
    t_exact();
    t_wrap_unav();
    t_abort();
    t_stray();
    t_restart();
    t_overrun();
    t_w1c();
    t_ring_end();
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule